// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the byte-wide, two-address register front end of an eight-line interrupt controller. Software writes configuration through it and reads state back. It does not arbitrate requests. A separate priority resolver keeps the pending and in-service registers and the rotating priority. The resolver gives this block its current winning line, and this block sends back one-cycle command strobes: end-of-interrupt, priority rotation and a full clear at initialization.

Address 0 takes the first initialization word and the two operation words. Bit 4 selects the initialization word. With bit 4 clear, bit 3 chooses between the mode/read command (bit 3 set) and the end-of-interrupt/priority command (bit 3 clear). Address 1 loads the line mask in normal operation. While an initialization sequence is open, address 1 instead feeds the sequence, which collects a vector base, an optional cascade word and an optional mode word. Reads return the pending register, the in-service register or the mask. A polling command turns the next read into an acknowledge. A separate acknowledge input presents an interrupt vector built from the base and the winning line.

Top module: `pic_cmd_if`

## Requirements
- R1: An address-0 write with bit 4 = 1 and bit 3 = 0 starts initialization. One cycle later the following hold: mask = 0, vector base = 0, all mode flags = 0, read select = pending, poll = off, `init_busy_o` = 1, and `init_clear_o` pulses for exactly one cycle. Bit 0 records whether a mode word will follow. Bit 1 records single (non-cascaded) operation.
- R2: An address-0 write with bit 4 = 1 and bit 3 = 1 (a level-trigger request) has no effect. No strobe fires, and the mask, flags and sequence are unchanged.
- R3: The first address-1 write after R1 sets the vector base to data bits 7:3. The sequence then continues as follows: if single and a mode word is needed, it waits for the mode word; if single and no mode word is needed, it returns to normal; if not single, it waits for a cascade word. The cascade word is discarded, and the sequence then waits for the mode word if one is needed, otherwise it returns to normal.
- R4: In the mode word, bit 4 sets special fully nested mode and bit 1 sets auto-EOI. The sequence then returns to normal and `init_busy_o` drops.
- R5: In normal operation an address-1 write loads the mask one cycle later. While the sequence is open, address-1 writes never change the mask.
- R6: An address-0 write with bit 4 = 0 and bit 3 = 1 is the mode/read command. Bit 2 = 1 arms poll. If bit 1 = 1, bit 0 selects the read source (1 = in-service, 0 = pending); otherwise the read source is kept. If bit 6 = 1, bit 5 sets the special-mask flag; otherwise the flag is kept.
- R7: An address-0 write with bits 4 and 3 clear is the EOI/priority command, with code = bits 7:5. Code 1 pulses `eoi_any_o`. Code 5 pulses `eoi_any_o` and `rotate_o`. Code 3 pulses `eoi_line_o`. Code 7 pulses `eoi_line_o` and `rotate_o`. Code 6 pulses `prio_set_o`. For codes 3, 6 and 7, `cmd_line_o` = bits 2:0. Each strobe lasts exactly one cycle after the write.
- R8: Codes 0 and 4 set the rotate-on-auto-EOI flag to bit 7 and pulse no strobe. Code 2 pulses nothing and changes no flag.
- R9: A read without poll armed puts data on `rdata_o` one cycle later. Address 0 returns the in-service or pending input according to the read select. Address 1 returns the mask.
- R10: A read with poll armed returns 0x80 | line and pulses `ack_o` with `ack_line_o` = line if a winner exists. With no winner it returns 0x00 and gives no acknowledge. Poll is then disarmed, so the next read is a normal register read.
- R11: A pulse on `inta_i` sets `vector_o` = base·8 + winning line one cycle later and pulses `ack_o`. With no winner, `vector_o` = base·8 + 7 and no acknowledge is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register address (0 or 1) |
| wdata | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid one cycle after `rd_en` |
| irr_i | input | 8 | Pending-request register from the resolver |
| isr_i | input | 8 | In-service register from the resolver |
| win_valid_i | input | 1 | Resolver has a winning line |
| win_line_i | input | 3 | Winning line number |
| inta_i | input | 1 | Interrupt acknowledge request |
| vector_o | output | 8 | Vector presented on acknowledge |
| ack_o | output | 1 | Acknowledge strobe to the resolver |
| ack_line_o | output | 3 | Line being acknowledged |
| mask_o | output | 8 | Line mask register |
| vec_base_o | output | 5 | Vector base (upper five bits) |
| init_busy_o | output | 1 | Initialization sequence open |
| init_clear_o | output | 1 | One-cycle clear strobe on initialization |
| spec_nested_o | output | 1 | Special fully nested mode flag |
| auto_eoi_o | output | 1 | Auto-EOI flag |
| rot_aeoi_o | output | 1 | Rotate-on-auto-EOI flag |
| special_mask_o | output | 1 | Special-mask flag |
| eoi_any_o | output | 1 | Non-specific EOI strobe |
| eoi_line_o | output | 1 | Specific EOI strobe |
| prio_set_o | output | 1 | Set-priority strobe |
| rotate_o | output | 1 | Rotate strobe accompanying an EOI |
| cmd_line_o | output | 3 | Line operand of the last EOI/priority command |

## Verification
Every result of this block comes from a register. A write, a read or an acknowledge sampled on one edge is therefore visible from that edge until the next, and each check is due exactly one cycle after its stimulus. The driver sets inputs on the falling edge, records the result due at the next cycle count, and drops the inputs one falling edge later. The monitor compares only on falling edges whose cycle count matches the recorded due cycle. Strobes are checked as single pulses, so a strobe that stays high or fires a cycle late is caught on the check that follows.

// File: rtl/pic_cmd_pkg.sv
// Package: shared types for the interrupt controller command interface.
// Assumes an 8-bit data bus and the fixed bit positions of the command words.
package pic_cmd_pkg;

    // Initialization sequence states; the numbering follows the word order.
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_BASE  = 2'd1,
        ST_CASC  = 2'd2,
        ST_MODE  = 2'd3
    } init_st_t;

    // EOI/priority command codes (write data bits 7:5).
    typedef enum logic [2:0] {
        OP_AEOI_OFF  = 3'd0,
        OP_EOI_ANY   = 3'd1,
        OP_NOP       = 3'd2,
        OP_EOI_LINE  = 3'd3,
        OP_AEOI_ON   = 3'd4,
        OP_EOI_ROT   = 3'd5,
        OP_PRIO_SET  = 3'd6,
        OP_EOI_LROT  = 3'd7
    } op_code_t;

endpackage

// File: rtl/pic_cmd_decode.sv
// Module: pic_cmd_decode
// Classifies one bus write into the kind of command word it carries.
// Assumes at most one write per cycle; purely combinational.
module pic_cmd_decode (
    input  logic       wr_en,
    input  logic       addr,
    input  logic [1:0] sel_bits,    // write data bits 4:3
    output logic       is_init,
    output logic       is_level_req,
    output logic       is_op_mode,
    output logic       is_op_eoi,
    output logic       is_data
);

    // Decode address and selector bits into exclusive word kinds.
    always_comb begin
        is_init      = wr_en && !addr &&  sel_bits[1] && !sel_bits[0];
        is_level_req = wr_en && !addr &&  sel_bits[1] &&  sel_bits[0];
        is_op_mode   = wr_en && !addr && !sel_bits[1] &&  sel_bits[0];
        is_op_eoi    = wr_en && !addr && !sel_bits[1] && !sel_bits[0];
        is_data      = wr_en &&  addr;
    end

endmodule

// File: rtl/pic_init_seq.sv
// Module: pic_init_seq
// Runs the initialization word sequence, owns the mask, the vector base
// and the flags set by the mode word. Assumes LINES <= DATA_W.
module pic_init_seq
    import pic_cmd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LINES  = 8,
    localparam int LW     = $clog2(LINES),
    localparam int BASE_W = DATA_W - LW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_init,
    input  logic              is_data,
    input  logic [DATA_W-1:0] wdata,
    output logic [LINES-1:0]  mask,
    output logic [BASE_W-1:0] base,
    output logic              spec_nested,
    output logic              auto_eoi,
    output logic              busy,
    output logic              init_clear
);

    init_st_t st;
    logic     need_mode;
    logic     single;

    // Sequence state, configuration capture and clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_READY;
            need_mode   <= 1'b0;
            single      <= 1'b0;
            mask        <= '0;
            base        <= '0;
            spec_nested <= 1'b0;
            auto_eoi    <= 1'b0;
            init_clear  <= 1'b0;
        end else begin
            init_clear <= 1'b0;
            if (is_init) begin
                st          <= ST_BASE;
                need_mode   <= wdata[0];
                single      <= wdata[1];
                mask        <= '0;
                base        <= '0;
                spec_nested <= 1'b0;
                auto_eoi    <= 1'b0;
                init_clear  <= 1'b1;
            end else if (is_data) begin
                unique case (st)
                    ST_READY: mask <= wdata[LINES-1:0];
                    ST_BASE: begin
                        base <= wdata[DATA_W-1:LW];
                        if (single) st <= need_mode ? ST_MODE : ST_READY;
                        else        st <= ST_CASC;
                    end
                    ST_CASC:  st <= need_mode ? ST_MODE : ST_READY;
                    ST_MODE: begin
                        spec_nested <= wdata[4];
                        auto_eoi    <= wdata[1];
                        st          <= ST_READY;
                    end
                endcase
            end
        end
    end

    // Sequence open flag.
    always_comb busy = (st != ST_READY);

    // R1: an initialization word opens the base step and fires the clear.
    assert_init_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
        is_init |=> (st == ST_BASE) && init_clear && (mask == '0));

    // R1: the clear strobe lasts one cycle.
    assert_clear_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        init_clear && !is_init |=> !init_clear);

    // R5: while the sequence is open, data writes never touch the mask.
    assert_mask_guarded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && is_data && !is_init |=> $stable(mask));

    // R3: the cascade word leads to the mode step only when one is needed.
    assert_casc_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CASC) && is_data && !is_init && !need_mode |=> (st == ST_READY));

endmodule

// File: rtl/pic_op_ctrl.sv
// Module: pic_op_ctrl
// Handles both operation words: mode/read flags, poll arming and the
// EOI/priority strobes to the resolver. Poll is disarmed by any read.
module pic_op_ctrl
    import pic_cmd_pkg::*;
#(
    parameter int LINES = 8,
    localparam int LW   = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_init,
    input  logic          is_op_mode,
    input  logic          is_op_eoi,
    input  logic          rd_en,
    input  logic [2:0]    hi_bits,   // write data bits 7:5
    input  logic [2:0]    lo_bits,   // write data bits 2:0
    output logic          poll,
    output logic          rd_isr,
    output logic          special_mask,
    output logic          rot_aeoi,
    output logic          eoi_any,
    output logic          eoi_line,
    output logic          prio_set,
    output logic          rotate,
    output logic [LW-1:0] cmd_line
);

    op_code_t code;

    // Command code view of the upper bits.
    always_comb code = op_code_t'(hi_bits);

    // Mode flags and poll arming.
    always_ff @(posedge clk) begin
        if (!rst_n || is_init) begin
            poll         <= 1'b0;
            rd_isr       <= 1'b0;
            special_mask <= 1'b0;
            rot_aeoi     <= 1'b0;
        end else begin
            if (rd_en) poll <= 1'b0;
            if (is_op_mode) begin
                if (lo_bits[2]) poll <= 1'b1;
                if (lo_bits[1]) rd_isr <= lo_bits[0];
                if (hi_bits[1]) special_mask <= hi_bits[0];
            end
            if (is_op_eoi && (code == OP_AEOI_OFF || code == OP_AEOI_ON))
                rot_aeoi <= hi_bits[2];
        end
    end

    // One-cycle EOI and priority strobes with their line operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_any  <= 1'b0;
            eoi_line <= 1'b0;
            prio_set <= 1'b0;
            rotate   <= 1'b0;
            cmd_line <= '0;
        end else begin
            eoi_any  <= is_op_eoi && (code == OP_EOI_ANY  || code == OP_EOI_ROT);
            eoi_line <= is_op_eoi && (code == OP_EOI_LINE || code == OP_EOI_LROT);
            prio_set <= is_op_eoi && (code == OP_PRIO_SET);
            rotate   <= is_op_eoi && (code == OP_EOI_ROT  || code == OP_EOI_LROT);
            if (is_op_eoi) cmd_line <= lo_bits[LW-1:0];
        end
    end

    // R7: at most one kind of EOI/priority strobe at a time.
    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eoi_any, eoi_line, prio_set}));

    // R7: rotation only accompanies an end-of-interrupt.
    assert_rotate_with_eoi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rotate |-> (eoi_any || eoi_line));

    // R8: the no-operation code fires nothing and keeps the flag.
    assert_nop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_op_eoi && (hi_bits == 3'd2) |=> !eoi_any && !eoi_line && !prio_set && $stable(rot_aeoi));

    // R10: a read disarms poll unless poll is re-armed in the same cycle.
    assert_poll_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !(is_op_mode && lo_bits[2]) |=> !poll);

    // R6: read select follows bit 0 when bit 1 enables it.
    assert_rdsel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_op_mode && lo_bits[1] && !is_init |=> (rd_isr == $past(lo_bits[0])));

endmodule

// File: rtl/pic_read_port.sv
// Module: pic_read_port
// Produces read data, the polled acknowledge and the acknowledge vector.
// Assumes the resolver's winner inputs are valid in the cycle of the read.
module pic_read_port #(
    parameter int DATA_W = 8,
    parameter int LINES  = 8,
    localparam int LW     = $clog2(LINES),
    localparam int BASE_W = DATA_W - LW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              addr,
    input  logic              poll,
    input  logic              rd_isr,
    input  logic [LINES-1:0]  irr,
    input  logic [LINES-1:0]  isr,
    input  logic [LINES-1:0]  mask,
    input  logic [BASE_W-1:0] base,
    input  logic              win_valid,
    input  logic [LW-1:0]     win_line,
    input  logic              inta,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] vector,
    output logic              ack,
    output logic [LW-1:0]     ack_line
);

    localparam logic [LW-1:0] SPURIOUS = '1;

    logic [DATA_W-1:0] poll_word;
    logic [DATA_W-1:0] reg_word;

    // Poll result byte and normal register byte.
    always_comb begin
        poll_word = '0;
        if (win_valid) begin
            poll_word[DATA_W-1]  = 1'b1;
            poll_word[LW-1:0]    = win_line;
        end
        reg_word = '0;
        if (addr)        reg_word[LINES-1:0] = mask;
        else if (rd_isr) reg_word[LINES-1:0] = isr;
        else             reg_word[LINES-1:0] = irr;
    end

    // Registered read data, vector and acknowledge strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            vector   <= '0;
            ack      <= 1'b0;
            ack_line <= '0;
        end else begin
            ack <= 1'b0;
            if (rd_en) rdata <= poll ? poll_word : reg_word;
            if (inta) vector <= {base, win_valid ? win_line : SPURIOUS};
            if (win_valid && ((rd_en && poll) || inta)) begin
                ack      <= 1'b1;
                ack_line <= win_line;
            end
        end
    end

    // R10: a polled read with a winner returns bit 7 set and acknowledges.
    assert_poll_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && poll && win_valid |=> rdata[DATA_W-1] && ack);

    // R11: an acknowledge without a winner reports the spurious line, no strobe.
    assert_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
        inta && !win_valid && !(rd_en && poll) |=> (vector[LW-1:0] == SPURIOUS) && !ack);

    // R10: no acknowledge without a polled read or an acknowledge request.
    assert_ack_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past((rd_en && poll) || inta));

endmodule

// File: rtl/pic_cmd_if.sv
// Module: pic_cmd_if (top)
// Register front end of an eight-line interrupt controller. Decodes writes,
// runs initialization, keeps mode flags and serves reads and acknowledges.
// Assumes the priority resolver is external and supplies pending, in-service
// and winner information.
module pic_cmd_if #(
    parameter int DATA_W = 8,
    parameter int LINES  = 8,
    localparam int LW     = $clog2(LINES),
    localparam int BASE_W = DATA_W - LW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [LINES-1:0]  irr_i,
    input  logic [LINES-1:0]  isr_i,
    input  logic              win_valid_i,
    input  logic [LW-1:0]     win_line_i,
    input  logic              inta_i,
    output logic [DATA_W-1:0] vector_o,
    output logic              ack_o,
    output logic [LW-1:0]     ack_line_o,
    output logic [LINES-1:0]  mask_o,
    output logic [BASE_W-1:0] vec_base_o,
    output logic              init_busy_o,
    output logic              init_clear_o,
    output logic              spec_nested_o,
    output logic              auto_eoi_o,
    output logic              rot_aeoi_o,
    output logic              special_mask_o,
    output logic              eoi_any_o,
    output logic              eoi_line_o,
    output logic              prio_set_o,
    output logic              rotate_o,
    output logic [LW-1:0]     cmd_line_o
);

    logic is_init, is_level_req, is_op_mode, is_op_eoi, is_data;
    logic poll, rd_isr;

    pic_cmd_decode u_decode (
        .wr_en        (wr_en),
        .addr         (addr),
        .sel_bits     (wdata[4:3]),
        .is_init      (is_init),
        .is_level_req (is_level_req),
        .is_op_mode   (is_op_mode),
        .is_op_eoi    (is_op_eoi),
        .is_data      (is_data)
    );

    pic_init_seq #(.DATA_W(DATA_W), .LINES(LINES)) u_init (
        .clk         (clk),
        .rst_n       (rst_n),
        .is_init     (is_init),
        .is_data     (is_data),
        .wdata       (wdata),
        .mask        (mask_o),
        .base        (vec_base_o),
        .spec_nested (spec_nested_o),
        .auto_eoi    (auto_eoi_o),
        .busy        (init_busy_o),
        .init_clear  (init_clear_o)
    );

    pic_op_ctrl #(.LINES(LINES)) u_op (
        .clk          (clk),
        .rst_n        (rst_n),
        .is_init      (is_init),
        .is_op_mode   (is_op_mode),
        .is_op_eoi    (is_op_eoi),
        .rd_en        (rd_en),
        .hi_bits      (wdata[7:5]),
        .lo_bits      (wdata[2:0]),
        .poll         (poll),
        .rd_isr       (rd_isr),
        .special_mask (special_mask_o),
        .rot_aeoi     (rot_aeoi_o),
        .eoi_any      (eoi_any_o),
        .eoi_line     (eoi_line_o),
        .prio_set     (prio_set_o),
        .rotate       (rotate_o),
        .cmd_line     (cmd_line_o)
    );

    pic_read_port #(.DATA_W(DATA_W), .LINES(LINES)) u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .addr      (addr),
        .poll      (poll),
        .rd_isr    (rd_isr),
        .irr       (irr_i),
        .isr       (isr_i),
        .mask      (mask_o),
        .base      (vec_base_o),
        .win_valid (win_valid_i),
        .win_line  (win_line_i),
        .inta      (inta_i),
        .rdata     (rdata_o),
        .vector    (vector_o),
        .ack       (ack_o),
        .ack_line  (ack_line_o)
    );

    // R2: a level-trigger request word opens nothing and clears nothing.
    assert_level_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_level_req |=> !init_clear_o && $stable(mask_o) && $stable(init_busy_o));

endmodule

// File: tb/pic_cmd_if_tb_top.sv
// Scoreboard bench: driver tasks queue expected results with their due
// cycle, a monitor on the falling edge pops and compares them.
module pic_cmd_if_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, inta_i = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] irr_i = '0, isr_i = '0;
    logic       win_valid_i = 1'b0;
    logic [2:0] win_line_i = '0;
    logic [7:0] rdata_o, vector_o, mask_o;
    logic       ack_o, init_busy_o, init_clear_o, spec_nested_o, auto_eoi_o;
    logic       rot_aeoi_o, special_mask_o, eoi_any_o, eoi_line_o, prio_set_o, rotate_o;
    logic [2:0] ack_line_o, cmd_line_o;
    logic [4:0] vec_base_o;

    always #2 clk = ~clk;   // 250 MHz

    pic_cmd_if dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata_o(rdata_o), .irr_i(irr_i), .isr_i(isr_i),
        .win_valid_i(win_valid_i), .win_line_i(win_line_i), .inta_i(inta_i),
        .vector_o(vector_o), .ack_o(ack_o), .ack_line_o(ack_line_o),
        .mask_o(mask_o), .vec_base_o(vec_base_o), .init_busy_o(init_busy_o),
        .init_clear_o(init_clear_o), .spec_nested_o(spec_nested_o),
        .auto_eoi_o(auto_eoi_o), .rot_aeoi_o(rot_aeoi_o),
        .special_mask_o(special_mask_o), .eoi_any_o(eoi_any_o),
        .eoi_line_o(eoi_line_o), .prio_set_o(prio_set_o), .rotate_o(rotate_o),
        .cmd_line_o(cmd_line_o)
    );

    // Observation selectors.
    localparam int F_RDATA = 0, F_MASK = 1, F_BASE = 2, F_FLAGS = 3,
                   F_STRB_L = 4, F_ACK_L = 5, F_VEC = 6, F_STRB = 7, F_ACK = 8;

    typedef struct {
        int          due;
        string       req;
        int          field;
        logic [15:0] exp;
    } item_t;

    item_t q[$];
    int cycle = 0;
    int due = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always @(posedge clk) cycle <= cycle + 1;

    function automatic logic [15:0] observe(int field);
        case (field)
            F_RDATA:  return {8'h0, rdata_o};
            F_MASK:   return {8'h0, mask_o};
            F_BASE:   return {11'h0, vec_base_o};
            F_FLAGS:  return {11'h0, init_busy_o, spec_nested_o, auto_eoi_o, rot_aeoi_o, special_mask_o};
            F_STRB_L: return {8'h0, init_clear_o, eoi_any_o, eoi_line_o, prio_set_o, rotate_o, cmd_line_o};
            F_ACK_L:  return {12'h0, ack_o, ack_line_o};
            F_VEC:    return {8'h0, vector_o};
            F_STRB:   return {11'h0, init_clear_o, eoi_any_o, eoi_line_o, prio_set_o, rotate_o};
            default:  return {15'h0, ack_o};
        endcase
    endfunction

    // Monitor: compare every item whose due cycle has arrived.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cycle) begin
            item_t it;
            logic [15:0] act;
            it = q.pop_front();
            act = observe(it.field);
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s field=%0d actual=0x%0h expected=0x%0h (cycle %0d)",
                         it.req, it.field, act, it.exp, cycle);
            end
        end
    end

    task automatic expect_at(string req, int field, logic [15:0] exp);
        item_t it;
        it.due = due; it.req = req; it.field = field; it.exp = exp;
        q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; inta_i = 1'b0;
        due = cycle + 1;
    endtask

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b0; inta_i = 1'b0; addr = a; wdata = d;
        due = cycle + 1;
    endtask

    task automatic rd(logic a);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; inta_i = 1'b0; addr = a;
        due = cycle + 1;
    endtask

    task automatic ack_req();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; inta_i = 1'b1;
        due = cycle + 1;
    endtask

    // flags = {busy, spec_nested, auto_eoi, rot_aeoi, special_mask}
    // strobes = {init_clear, eoi_any, eoi_line, prio_set, rotate}
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        expect_at("R1 reset", F_MASK, 0);
        expect_at("R1 reset", F_FLAGS, 0);
        expect_at("R9 reset", F_RDATA, 0);
        expect_at("R7 reset", F_STRB, 0);

        // Single, mode word needed.
        wr(0, 8'h13); expect_at("R1", F_STRB, 5'b10000); expect_at("R1", F_FLAGS, 5'b10000); idle();
        expect_at("R1 pulse", F_STRB, 0);
        wr(1, 8'h48); expect_at("R3", F_BASE, 5'd9); expect_at("R3", F_FLAGS, 5'b10000); idle();
        wr(1, 8'h12); expect_at("R4", F_FLAGS, 5'b01100); idle();
        wr(1, 8'hA5); expect_at("R5", F_MASK, 8'hA5); idle();
        rd(1); expect_at("R9", F_RDATA, 8'hA5); idle();

        // Level-trigger request word is ignored.
        wr(0, 8'h1B); expect_at("R2", F_STRB, 0); expect_at("R2", F_MASK, 8'hA5);
        expect_at("R2", F_FLAGS, 5'b01100); expect_at("R2", F_BASE, 5'd9); idle();

        // Cascaded, no mode word.
        wr(0, 8'h10); expect_at("R1", F_MASK, 0); expect_at("R1", F_FLAGS, 5'b10000);
        expect_at("R1", F_BASE, 0); expect_at("R1", F_STRB, 5'b10000); idle();
        wr(1, 8'h20); expect_at("R3", F_BASE, 5'd4); expect_at("R3", F_FLAGS, 5'b10000); idle();
        wr(1, 8'hFF); expect_at("R3 cascade discarded", F_FLAGS, 0);
        expect_at("R5 mask guarded", F_MASK, 0); expect_at("R3", F_BASE, 5'd4); idle();
        wr(1, 8'h3C); expect_at("R5", F_MASK, 8'h3C); idle();

        // Cascaded with mode word.
        wr(0, 8'h11); idle();
        wr(1, 8'h08); expect_at("R3", F_BASE, 5'd1); idle();
        wr(1, 8'h77); expect_at("R3", F_FLAGS, 5'b10000); expect_at("R5", F_MASK, 0); idle();
        wr(1, 8'h00); expect_at("R4", F_FLAGS, 0); expect_at("R5", F_MASK, 0); idle();

        // Single, no mode word.
        wr(0, 8'h12); idle();
        wr(1, 8'hF8); expect_at("R3", F_BASE, 5'd31); expect_at("R3", F_FLAGS, 0); idle();

        // EOI / priority commands.
        wr(0, 8'h20); expect_at("R7 code1", F_STRB, 5'b01000); idle();
        expect_at("R7 pulse", F_STRB, 0);
        wr(0, 8'hA0); expect_at("R7 code5", F_STRB, 5'b01001); idle();
        wr(0, 8'h63); expect_at("R7 code3", F_STRB_L, {5'b00100, 3'd3}); idle();
        wr(0, 8'hE6); expect_at("R7 code7", F_STRB_L, {5'b00101, 3'd6}); idle();
        wr(0, 8'hC5); expect_at("R7 code6", F_STRB_L, {5'b00010, 3'd5}); idle();
        wr(0, 8'h80); expect_at("R8 code4", F_FLAGS, 5'b00010); expect_at("R8", F_STRB, 0); idle();
        wr(0, 8'h40); expect_at("R8 code2", F_FLAGS, 5'b00010); expect_at("R8", F_STRB, 0); idle();
        wr(0, 8'h00); expect_at("R8 code0", F_FLAGS, 0); idle();

        // Mode/read command and register reads.
        irr_i = 8'h33; isr_i = 8'h5A;
        rd(0); expect_at("R9 pending", F_RDATA, 8'h33); idle();
        wr(0, 8'h0B); idle();
        rd(0); expect_at("R6 in-service", F_RDATA, 8'h5A); idle();
        wr(0, 8'h09); idle();
        rd(0); expect_at("R6 select kept", F_RDATA, 8'h5A); idle();
        wr(0, 8'h0A); idle();
        rd(0); expect_at("R6 pending", F_RDATA, 8'h33); idle();
        wr(0, 8'h68); expect_at("R6 smask on", F_FLAGS, 5'b00001); idle();
        wr(0, 8'h28); expect_at("R6 smask kept", F_FLAGS, 5'b00001); idle();
        wr(0, 8'h48); expect_at("R6 smask off", F_FLAGS, 0); idle();

        // Poll.
        wr(1, 8'h5C); idle();
        win_valid_i = 1'b1; win_line_i = 3'd5;
        wr(0, 8'h0C); idle();
        rd(1); expect_at("R10 poll", F_RDATA, 8'h85); expect_at("R10 poll", F_ACK_L, {1'b1, 3'd5}); idle();
        expect_at("R10 ack pulse", F_ACK, 0);
        rd(1); expect_at("R10 poll cleared", F_RDATA, 8'h5C); expect_at("R10", F_ACK, 0); idle();
        win_valid_i = 1'b0;
        wr(0, 8'h0C); idle();
        rd(1); expect_at("R10 poll none", F_RDATA, 8'h00); expect_at("R10", F_ACK, 0); idle();

        // Acknowledge vector (base 31).
        win_valid_i = 1'b1; win_line_i = 3'd2;
        ack_req(); expect_at("R11", F_VEC, 8'hFA); expect_at("R11", F_ACK_L, {1'b1, 3'd2}); idle();
        win_valid_i = 1'b0;
        ack_req(); expect_at("R11 spurious", F_VEC, 8'hFF); expect_at("R11", F_ACK, 0); idle();

        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    // Watchdog and final report.
    initial begin
        int waited;
        waited = 0;
        while (!done && waited < 5000) begin
            @(posedge clk);
            waited++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        if (q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL scoreboard actual=%0d pending expected=0", q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule